// File: doc/BRIEF.md
# DMA and Interrupt Request Handshake

This block is the request logic that a peripheral on a PC/104 expansion bus needs. A local event asks for a DMA transfer. The block then drives its DMA request line high and holds it there until the host answers on the active-low acknowledge pin. The acknowledge is asynchronous to the local clock, so it first passes through a synchroniser. When the acknowledge is seen, the block gives a one-cycle go pulse that lets the local transfer engine start. It then drops the request and refuses new work until the host releases the acknowledge.

The same block also drives one interrupt line. The host detects an interrupt on a rising edge. The line goes high on a local event and stays high until local service logic acknowledges it. After that it is low for at least one clock. Events that arrive while the line is high, or during that gap cycle, are folded into a single pending request. That request produces a fresh rising edge once the gap has passed.

The DMA channel is a parameter. Channels 0 to 3 move bytes and channels 5 to 7 move 16-bit words. Channel 4 cannot be used. All pins are plain control levels: no data passes through the block, so there is no valid/ready interface and no back-pressure.

Top module: `dma_irq_req_top`

## Requirements
- R1: With the request line low and the synchronised acknowledge inactive, `xfer_req` high at a clock edge drives `dma_req` high from that edge on.
- R2: Once high, `dma_req` stays high on every clock until the synchronised acknowledge is seen; the length of the wait does not matter.
- R3: `dack_n` passes through SYNC_STAGES flops (default 2). If it is low at edge k, `dma_go` is high for exactly the one cycle between edges k+1 and k+2, and `dma_req` is low after edge k+2.
- R4: While the synchronised acknowledge stays active after a grant, `dma_req` stays low and `xfer_req` is ignored; it is not stored. The block accepts a new request only after `dack_n` has been seen high again.
- R5: `wide_xfer` is 1 for CHANNEL 5, 6 or 7 and 0 for CHANNEL 0 to 3. CHANNEL 4 or a value outside 0..7 stops elaboration.
- R6: With the interrupt line idle, `irq_event` high at an edge drives `irq_line` high after that edge. The line then stays high on every clock until `irq_ack` is sampled high.
- R7: `irq_ack` sampled high while `irq_line` is high drives the line low after that edge. The line then stays low for at least one full clock.
- R8: Any number of `irq_event` pulses that arrive while the line is high, or in the forced-low cycle, are merged into one pending request. That request raises the line again immediately after the forced-low cycle.
- R9: While `rst_n` is low, `dma_req`, `dma_go` and `irq_line` are 0 and the synchroniser holds the acknowledge as inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_req | input | 1 | Local request for one DMA service |
| dack_n | input | 1 | Host DMA acknowledge, active low, asynchronous |
| dma_req | output | 1 | DMA request line to the bus, active high |
| dma_go | output | 1 | One-cycle pulse: the transfer may begin |
| wide_xfer | output | 1 | 1 = 16-bit transfer channel, 0 = 8-bit |
| irq_event | input | 1 | Local event that needs host attention |
| irq_ack | input | 1 | Local service acknowledge for the interrupt |
| irq_line | output | 1 | Edge-style interrupt request line to the bus |

## Verification
The in-RTL assertions check four rules on every cycle: the DMA request holds until the synchronised acknowledge arrives, it falls on the clock after that acknowledge, it cannot rise again while the acknowledge persists, and the interrupt line holds until serviced and drops right after service. The synchroniser latency, the exact cycle of the go pulse, and the fact that requests made during a grant are dropped rather than queued can only be shown by the bench's scenarios. The same holds for merging several interrupt events into one later edge, and for the channel width flag.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

  typedef enum logic [1:0] {
    DMA_IDLE    = 2'd0,
    DMA_ASKING  = 2'd1,
    DMA_GRANTED = 2'd2
  } dma_state_e;

  typedef enum logic [1:0] {
    IRQ_QUIET  = 2'd0,
    IRQ_RAISED = 2'd1,
    IRQ_GAP    = 2'd2
  } irq_state_e;

  function automatic logic channel_is_wide(input int unsigned ch);
    return (ch >= 5) && (ch <= 7);
  endfunction

  function automatic logic channel_is_legal(input int unsigned ch);
    return (ch <= 7) && (ch != 4);
  endfunction

endpackage

// File: rtl/dir_sync_chain.sv
module dir_sync_chain #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] stage_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[gi] <= RESET_VAL;
        end else if (gi == 0) begin
          stage_q[gi] <= async_in;
        end else begin
          stage_q[gi] <= stage_q[(gi == 0) ? 0 : gi-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/dir_dma_fsm.sv
module dir_dma_fsm
  import dma_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ack_seen,
  output logic drq,
  output logic go
);

  dma_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      DMA_IDLE:    if (start && !ack_seen) state_d = DMA_ASKING;
      DMA_ASKING:  if (ack_seen)           state_d = DMA_GRANTED;
      DMA_GRANTED: if (!ack_seen)          state_d = DMA_IDLE;
      default:                             state_d = DMA_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= DMA_IDLE;
    else        state_q <= state_d;
  end

  assign drq = (state_q == DMA_ASKING);
  assign go  = (state_q == DMA_ASKING) && ack_seen;

  assert_drq_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (drq && !ack_seen) |=> drq)
    else $error("request dropped before acknowledge (R2)");

  assert_drq_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (drq && ack_seen) |=> !drq)
    else $error("request not released after acknowledge (R3)");

  assert_no_rearm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!drq && ack_seen) |=> !drq)
    else $error("request re-armed while acknowledge active (R4)");

endmodule

// File: rtl/dir_irq_fsm.sv
module dir_irq_fsm
  import dma_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic event_in,
  input  logic ack,
  output logic line
);

  irq_state_e state_q, state_d;
  logic       pend_q, pend_d;

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    unique case (state_q)
      IRQ_QUIET: begin
        if (event_in) state_d = IRQ_RAISED;
        pend_d = 1'b0;
      end
      IRQ_RAISED: begin
        if (event_in) pend_d = 1'b1;
        if (ack)      state_d = IRQ_GAP;
      end
      IRQ_GAP: begin
        if (pend_q || event_in) begin
          state_d = IRQ_RAISED;
          pend_d  = 1'b0;
        end else begin
          state_d = IRQ_QUIET;
        end
      end
      default: begin
        state_d = IRQ_QUIET;
        pend_d  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= IRQ_QUIET;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  assign line = (state_q == IRQ_RAISED);

  assert_irq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (line && !ack) |=> line)
    else $error("interrupt released before service (R6)");

  assert_irq_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (line && ack) |=> !line)
    else $error("interrupt not lowered after service (R7)");

endmodule

// File: rtl/dma_irq_req_top.sv
module dma_irq_req_top
  import dma_irq_pkg::*;
#(
  parameter int unsigned CHANNEL     = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xfer_req,
  input  logic dack_n,
  output logic dma_req,
  output logic dma_go,
  output logic wide_xfer,
  input  logic irq_event,
  input  logic irq_ack,
  output logic irq_line
);

  localparam logic IS_WIDE = channel_is_wide(CHANNEL);

  generate
    if (!channel_is_legal(CHANNEL)) begin : g_bad_channel
      $error("dma_irq_req_top: CHANNEL must be 0..3 or 5..7");
    end
    if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("dma_irq_req_top: SYNC_STAGES must be at least 2");
    end
  endgenerate

  logic dack_n_sync;
  logic ack_seen;

  dir_sync_chain #(
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (1'b1)
  ) u_ack_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (dack_n),
    .sync_out (dack_n_sync)
  );

  assign ack_seen = !dack_n_sync;

  dir_dma_fsm u_dma (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (xfer_req),
    .ack_seen (ack_seen),
    .drq      (dma_req),
    .go       (dma_go)
  );

  dir_irq_fsm u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .event_in (irq_event),
    .ack      (irq_ack),
    .line     (irq_line)
  );

  assign wide_xfer = IS_WIDE;

endmodule

// File: tb/dma_irq_req_top_tb_top.sv
module dma_irq_req_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xfer_req = 1'b0;
  logic dack_n = 1'b1;
  logic irq_event = 1'b0;
  logic irq_ack = 1'b0;
  logic dma_req, dma_go, wide_xfer, irq_line;
  logic n_req, n_go, n_wide, n_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_irq_req_top #(.CHANNEL(6)) dut_i (
    .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .dack_n(dack_n),
    .dma_req(dma_req), .dma_go(dma_go), .wide_xfer(wide_xfer),
    .irq_event(irq_event), .irq_ack(irq_ack), .irq_line(irq_line)
  );

  dma_irq_req_top #(.CHANNEL(2)) dut_narrow_i (
    .clk(clk), .rst_n(rst_n), .xfer_req(1'b0), .dack_n(1'b1),
    .dma_req(n_req), .dma_go(n_go), .wide_xfer(n_wide),
    .irq_event(1'b0), .irq_ack(1'b0), .irq_line(n_irq)
  );

  // Behavioural reference model
  bit ack_hist[$];        // sampled dack_n, newest at front
  int m_dma;              // 0 idle, 1 asking, 2 granted
  bit m_line, m_gap, m_pend;

  function automatic bit m_ack_active();
    return ack_hist[1] == 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ack_hist = '{1'b1, 1'b1};
      m_dma = 0; m_line = 0; m_gap = 0; m_pend = 0;
    end else begin
      bit ack_now;
      ack_now = m_ack_active();
      ack_hist.push_front(dack_n);
      void'(ack_hist.pop_back());
      if (m_dma == 0)      begin if (xfer_req && !ack_now) m_dma = 1; end
      else if (m_dma == 1) begin if (ack_now) m_dma = 2; end
      else                 begin if (!ack_now) m_dma = 0; end
      if (m_line) begin
        if (irq_event) m_pend = 1;
        if (irq_ack) begin m_line = 0; m_gap = 1; end
      end else if (m_gap) begin
        m_gap = 0;
        if (m_pend || irq_event) begin m_line = 1; m_pend = 0; end
      end else begin
        m_pend = 0;
        if (irq_event) m_line = 1;
      end
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && ack_hist.size() == 2) begin
      check("R2 dma_req", dma_req, m_dma == 1);
      check("R3 dma_go", dma_go, (m_dma == 1) && m_ack_active());
      check("R6 irq_line", irq_line, m_line);
      check("R5 wide_xfer ch6", wide_xfer, 1'b1);
      check("R5 wide_xfer ch2", n_wide, 1'b0);
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    step(2);
    check("R9 reset dma_req", dma_req, 1'b0);
    check("R9 reset dma_go", dma_go, 1'b0);
    check("R9 reset irq_line", irq_line, 1'b0);
    rst_n = 1'b1;
    step(2);

    // R1 / R3: request, then acknowledge through the synchroniser
    xfer_req = 1'b1; step();
    check("R1 request raised", dma_req, 1'b1);
    xfer_req = 1'b0; step(6);
    check("R2 request held while waiting", dma_req, 1'b1);
    dack_n = 1'b0; step();
    check("R3 no go before sync", dma_go, 1'b0);
    step();
    check("R3 go pulse", dma_go, 1'b1);
    check("R3 request still high with go", dma_req, 1'b1);
    step();
    check("R3 request released", dma_req, 1'b0);
    check("R3 go single cycle", dma_go, 1'b0);

    // R4: requests during grant are ignored, not stored
    xfer_req = 1'b1; step(4);
    check("R4 no rearm while acked", dma_req, 1'b0);
    xfer_req = 1'b0; dack_n = 1'b1; step(6);
    check("R4 dropped request not queued", dma_req, 1'b0);
    xfer_req = 1'b1; step();
    check("R4 new request accepted after release", dma_req, 1'b1);
    xfer_req = 1'b0; dack_n = 1'b0; step(3);
    dack_n = 1'b1; step(4);

    // R6 / R7: single interrupt
    irq_event = 1'b1; step();
    check("R6 irq raised", irq_line, 1'b1);
    irq_event = 1'b0; step(5);
    check("R6 irq held", irq_line, 1'b1);
    irq_ack = 1'b1; step();
    check("R7 irq lowered", irq_line, 1'b0);
    irq_ack = 1'b0; step();
    check("R7 irq stays low without event", irq_line, 1'b0);

    // R8: events while high merge into one later edge
    irq_event = 1'b1; step();
    irq_event = 1'b1; step();
    irq_event = 1'b0; step();
    irq_event = 1'b1; step();
    irq_event = 1'b0; irq_ack = 1'b1; step();
    irq_ack = 1'b0;
    check("R7 gap cycle low", irq_line, 1'b0);
    step();
    check("R8 pending raises line again", irq_line, 1'b1);
    irq_ack = 1'b1; step();
    irq_ack = 1'b0; step(3);
    check("R8 merged events give one edge", irq_line, 1'b0);

    // R8: event during the gap cycle
    irq_event = 1'b1; step();
    irq_event = 1'b0; irq_ack = 1'b1; step();
    irq_ack = 1'b0; irq_event = 1'b1; step();
    irq_event = 1'b0;
    check("R8 gap event raises line", irq_line, 1'b1);
    irq_ack = 1'b1; step();
    irq_ack = 1'b0; step(2);

    // Pseudo-random traffic, compared every cycle with the model
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      xfer_req  = lfsr[0] & lfsr[3];
      irq_event = lfsr[5] & lfsr[7] & lfsr[2];
      irq_ack   = lfsr[9] & lfsr[1];
      if (lfsr[11] & lfsr[4] & lfsr[8]) dack_n = ~dack_n;
      step();
    end
    xfer_req = 0; irq_event = 0; irq_ack = 0; dack_n = 1;
    step(4);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule